// File: doc/BRIEF.md
# Dual-Channel Register-Driven PWM Generator

This block generates two pulse-width modulated outputs. Each output takes its settings from a small group of byte registers: a 16-bit on-time count, a 16-bit period count and an 8-bit clock divider. The register contents arrive as plain parallel inputs, one flat vector in which byte `i` holds register `0x02 + i`. Channel 0 uses registers 0x02 to 0x06 and channel 1 uses registers 0x07 to 0x0B.

Inside each channel, a prescaler counts system clocks up to the divider value and emits a tick. A period counter advances on every tick and wraps at the end of the period. The output is high while the count is below the on-time count. A divider of zero turns the channel off. When the period count is below the on-time count, the output is held high.

New settings are copied into a shadow set only when a period ends, or at any clock edge while the channel is off. A change made in mid-period therefore never cuts a pulse short.

Top module: `pwm_dual_regs`

## Requirements
- R1: Within channel k, register `0x02+5k+n` holds the following field for each offset n: n=0 is the on-time low byte, n=1 the on-time high byte, n=2 the period low byte, n=3 the period high byte and n=4 the divider. Byte `i` of `cfg_regs` is bits `[8i+7:8i]`.
- R2: While `rst` (active high, asynchronous) is asserted, every output is low and every channel is off.
- R3: A channel whose active divider is 0 drives its output low. A divider of 0 written during a running period takes effect at the end of that period.
- R4: Counting from the start of a period, the output is high for exactly on-time × divider system clocks, provided the on-time does not exceed the period count.
- R5: A period lasts max(period count, 1) × divider system clocks. The output rises again at the first clock of the next period when the on-time is nonzero.
- R6: When the period count is below the on-time count and the divider is nonzero, the output stays high on every clock.
- R7: An on-time count of 0 with a nonzero divider keeps the output low.
- R8: While a channel runs, its active settings change only at a period boundary. While it is off, the settings present at a clock edge become active at that edge.
- R9: The two channels run independently of each other, each from its own register group.
- R10: The prescaler tick arrives once every divider system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_regs | input | 80 | Registers 0x02 to 0x0B; byte i is register 0x02+i |
| pwm_out | output | 2 | PWM outputs; bit k belongs to channel k |

## Verification
The assertions check four things on every cycle: the tick spacing, that the period count stays below the active period count, that the shadow settings stay stable between period boundaries, and that the output rises only at count zero. They also check that a zero divider seen at a load silences the output. The bench scenarios are what show the absolute numbers: the number of high clocks per period for chosen settings, the period length, the byte layout with nonzero high bytes, the delayed effect of a mid-period change, and the independence of the two channels. A cycle-by-cycle reference model in the bench covers every clock of these scenarios.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
  localparam int CNT_W       = 16;
  localparam int DIV_W       = 8;
  localparam int CNT_BYTES   = CNT_W / 8;
  localparam int DIV_BYTES   = (DIV_W + 7) / 8;
  localparam int REGS_PER_CH = 2 * CNT_BYTES + DIV_BYTES;
  localparam int CH_BITS     = REGS_PER_CH * 8;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    div_t div;
    cnt_t total;
    cnt_t high;
  } chan_cfg_t;

  // Little-endian byte order: on-time, then period, then divider
  function automatic chan_cfg_t unpack_cfg(input logic [CH_BITS-1:0] bytes);
    chan_cfg_t c;
    c.high  = bytes[CNT_W-1:0];
    c.total = bytes[2*CNT_W-1:CNT_W];
    c.div   = bytes[2*CNT_W+DIV_W-1:2*CNT_W];
    return c;
  endfunction

  function automatic logic last_of_period(input cnt_t cnt, input cnt_t total);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, total};
  endfunction

  function automatic logic last_of_prescale(input div_t pre, input div_t div);
    return pre == div_t'(div - 1'b1);
  endfunction

  function automatic logic out_level(input cnt_t cnt, input chan_cfg_t c);
    return (c.div != '0) && ((c.total < c.high) || (cnt < c.high));
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_regs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  div_t div,
  output logic tick
);
  div_t pre_q;

  assign tick = en && last_of_prescale(pre_q, div);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            pre_q <= '0;
    else if (!en)       pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  // R10: with an unchanged divider above 1, ticks never come back to back
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && div > div_t'(1)) |=> (!tick || !$stable(div)));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_regs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  cnt_t total,
  output cnt_t cnt,
  output logic wrap
);
  cnt_t cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && last_of_period(cnt_q, total);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_regs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  chan_cfg_t cfg_live,
  output logic      pwm
);
  chan_cfg_t act_q;
  logic      run;
  logic      tick_evt;
  logic      wrap_evt;
  logic      load_evt;
  cnt_t      cnt;

  assign run      = act_q.div != '0;
  assign load_evt = !run || wrap_evt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           act_q <= '0;
    else if (load_evt) act_q <= cfg_live;
  end

  pwm_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (run),
    .div  (act_q.div),
    .tick (tick_evt)
  );

  pwm_period_ctr u_ctr (
    .clk   (clk),
    .rst   (rst),
    .clr   (!run),
    .tick  (tick_evt),
    .total (act_q.total),
    .cnt   (cnt),
    .wrap  (wrap_evt)
  );

  assign pwm = out_level(cnt, act_q);

  // R8: shadow settings hold between loads
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(act_q));

  // R5: counter stays inside the active period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (act_q.total != '0) |-> (cnt < act_q.total));

  // R4: a pulse only starts at the first count of a period
  p_rise_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm) |-> (cnt == '0));

  // R3: a zero divider taken at a load silences the output
  p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(load_evt) && ($past(cfg_live.div) == '0)) |-> !pwm);
endmodule

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_regs_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH*CH_BITS-1:0] cfg_regs,
  output logic [NUM_CH-1:0]         pwm_out
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    chan_cfg_t cfg_k;
    assign cfg_k = unpack_cfg(cfg_regs[k*CH_BITS +: CH_BITS]);

    pwm_channel u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg_live (cfg_k),
      .pwm      (pwm_out[k])
    );
  end
endmodule

// File: tb/tb_pwm_dual_regs.sv
`timescale 1ns/1ps
module tb_pwm_dual_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [79:0] cfg = '0;
  logic [1:0]  pwm;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_dual_regs dut (.clk(clk), .rst(rst), .cfg_regs(cfg), .pwm_out(pwm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: each channel takes five bytes: on-time lo/hi, period lo/hi, divider
  task automatic set_ch(input int ch, input int h, input int t, input int d);
    cfg[ch*40 +: 8]      = h[7:0];
    cfg[ch*40 + 8 +: 8]  = h[15:8];
    cfg[ch*40 + 16 +: 8] = t[7:0];
    cfg[ch*40 + 24 +: 8] = t[15:8];
    cfg[ch*40 + 32 +: 8] = d[7:0];
  endtask

  // Behavioural reference, one integer state per channel
  int mh[2], mt[2], md[2], mp[2], mc[2];
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      int lh, lt, ld;
      lh = cfg[c*40 +: 16];
      lt = cfg[c*40 + 16 +: 16];
      ld = cfg[c*40 + 32 +: 8];
      if (rst) begin
        mh[c] = 0; mt[c] = 0; md[c] = 0; mp[c] = 0; mc[c] = 0;
      end else if (md[c] == 0) begin
        mh[c] = lh; mt[c] = lt; md[c] = ld; mp[c] = 0; mc[c] = 0;
      end else if (mp[c] + 1 >= md[c]) begin
        mp[c] = 0;
        if (mc[c] + 1 >= mt[c]) begin
          mc[c] = 0; mh[c] = lh; mt[c] = lt; md[c] = ld;
        end else mc[c]++;
      end else mp[c]++;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        int e;
        e = (md[c] != 0 && (mt[c] < mh[c] || mc[c] < mh[c])) ? 1 : 0;
        chk(pwm[c] == e[0], $sformatf("R9 model ch%0d", c), pwm[c], e);
      end
    end
  end

  task automatic restart();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  // R4 R5 R6 R7: one period from a fresh start, then the first clock of the next
  task automatic measure(input int ch, input int h, input int t, input int d);
    int p, hc, eh;
    set_ch(ch, h, t, d);
    restart();
    p  = ((t > 0) ? t : 1) * d;
    hc = 0;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      hc += pwm[ch];
    end
    eh = (t < h) ? p : h * d;
    chk(hc == eh, "R4 high clocks per period", hc, eh);
    @(negedge clk);
    chk(pwm[ch] == (h > 0), "R5 next period starts", pwm[ch], (h > 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hc0, hc1;
    repeat (2) @(negedge clk);
    chk(pwm == 2'b00, "R2 reset outputs low", pwm, 0);
    rst = 1'b0;

    measure(0, 3, 10, 4);
    measure(0, 0, 5, 2);       // R7
    measure(0, 9, 4, 3);       // R6
    measure(1, 259, 512, 1);   // R1 high bytes nonzero
    set_ch(1, 0, 0, 0);

    // R3: zero divider keeps output low
    set_ch(0, 5, 8, 0);
    restart();
    hc0 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      hc0 += pwm[0];
    end
    chk(hc0 == 0, "R3 divider zero low", hc0, 0);

    // R8: mid-period change applies at the next period
    set_ch(0, 2, 4, 3);
    restart();
    for (int k = 0; k < 6; k++) @(negedge clk);
    set_ch(0, 3, 4, 3);
    @(negedge clk);            // sample 6, old on-time still active
    chk(pwm[0] == 1'b0, "R8 old setting kept", pwm[0], 0);
    for (int k = 7; k <= 18; k++) @(negedge clk);
    chk(pwm[0] == 1'b1, "R8 new setting at boundary", pwm[0], 1);

    // R3: disable during a running period
    set_ch(0, 2, 4, 3);
    restart();
    for (int k = 0; k < 4; k++) @(negedge clk);
    set_ch(0, 2, 4, 0);
    @(negedge clk);            // sample 4, period continues
    chk(pwm[0] == 1'b1, "R3 period completes", pwm[0], 1);
    for (int k = 5; k <= 14; k++) @(negedge clk);
    chk(pwm[0] == 1'b0, "R3 off after boundary", pwm[0], 0);

    // R9: channels side by side
    set_ch(0, 1, 4, 2);
    set_ch(1, 3, 3, 2);
    restart();
    hc0 = 0; hc1 = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      hc0 += pwm[0];
      hc1 += pwm[1];
    end
    chk(hc0 == 6, "R9 channel 0 duty", hc0, 6);
    chk(hc1 == 24, "R9 channel 1 duty", hc1, 24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule